// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral and Retry Controller

This block decides when an Ethernet transmitter may put a frame on the wire and what happens after a collision. Once the medium falls quiet, it enforces the inter-frame gap in two parts. The first part is a watch window in which a returning carrier sends the wait back to the beginning. The second part is a fixed tail that ignores the carrier. When the gap is met and a frame is pending, it grants transmission.

During a transmission in half-duplex mode, a collision causes the following sequence:
- The grant is withdrawn.
- A jam of a fixed number of bit times is requested.
- The collision is classed as early or late, using the number of bytes already sent.
- An early collision counts one attempt. The block then waits a pseudo-random number of slot times (truncated binary exponential backoff) and asks the data path to rewind to the frame start.
- A late collision, or a collision past the retry limit, abandons the frame and raises a one-cycle flag.

In full-duplex mode carrier and collision are ignored. Only the gap is timed.

All timing is counted in `bit_tick` pulses, and the serialiser reports the end of a good frame with `frame_end`.

Top module: `hdx_defer_retry`

## Requirements
- R1: While reset is held and on the first cycles after release, `tx_grant`, `jam_req`, `rewind_req`, `late_col` and `retry_lim` are all 0.
- R2: In half-duplex mode, while `carrier_sense` stays high, `tx_grant` never rises, even with a frame pending.
- R3: If `carrier_sense` returns high on any clock while the WINDOW_BITS watch window is being counted, the deferral restarts from the next clock on which it is low.
- R4: With one bit tick per clock and a frame pending, `tx_grant` rises on the clock edge WINDOW_BITS+TAIL_BITS edges after the first edge that samples `carrier_sense` low.
- R5: `carrier_sense` rising during the TAIL_BITS tail does not delay the grant computed under R4.
- R6: A half-duplex collision during transmission drops `tx_grant` on the next edge and holds `jam_req` high for exactly JAM_BITS bit ticks.
- R7: After the n-th early collision of a frame, the wait before the deferral restarts is k·SLOT_BITS bit ticks, with 0 ≤ k ≤ 2^min(n,BACKOFF_CAP)−1. The restarted deferral is timed as in R4. With one tick per clock, `tx_grant` returns k·SLOT_BITS+WINDOW_BITS+TAIL_BITS+2 clocks after `rewind_req` is seen.
- R8: A collision with `tx_byte_cnt` below KEEP_BYTES, within the retry limit, ends the jam with a one-cycle `rewind_req` and no other flag.
- R9: A collision with `tx_byte_cnt` at or above KEEP_BYTES ends the jam with a one-cycle `late_col`, no `rewind_req`, and abandons the frame.
- R10: The collision numbered RETRY_LIMIT+1 in one frame ends the jam with a one-cycle `retry_lim` and no `rewind_req`. The attempt count then restarts at zero, so the next collision rewinds again. `frame_end` also clears the count.
- R11: In full-duplex mode, `collision` neither drops `tx_grant` nor raises `jam_req`. `carrier_sense` is ignored, and the grant for the next frame rises WINDOW_BITS+TAIL_BITS+1 edges after the edge that samples `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1: full-duplex, carrier and collision ignored |
| bit_tick | input | 1 | One pulse per bit time |
| carrier_sense | input | 1 | Medium busy |
| collision | input | 1 | Collision detected on the medium |
| frame_pending | input | 1 | A frame waits to be sent |
| frame_end | input | 1 | Serialiser finished the current frame |
| tx_byte_cnt | input | BC_W | Bytes of the current frame already sent |
| tx_grant | output | 1 | Transmission permitted (level) |
| jam_req | output | 1 | Send the jam pattern (level) |
| rewind_req | output | 1 | Restart the frame from its first byte (pulse) |
| late_col | output | 1 | Frame abandoned on a late collision (pulse) |
| retry_lim | output | 1 | Frame abandoned at the retry limit (pulse) |

## Verification
The bench moves a carrier glitch through every position of the watch window and of the tail. A design that merged the two phases, or let the carrier reset the tail, would grant too late or too early at one of those positions. It sweeps the byte count across the late-collision boundary, where an off-by-one compare would rewind a frame it should abandon. It drives a frame through every collision up to and past the retry limit. This catches a count that aborts one attempt early, one that never clears after an abort, and a backoff whose length is not a whole number of slots or exceeds the capped range. Full-duplex runs confirm that neither a held carrier nor a collision disturbs the timing.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [1:0] {DF_WAIT, DF_WIN, DF_TAIL, DF_MET} dfr_state_t;
  typedef enum logic [1:0] {TX_DEFER, TX_SEND, TX_JAM, TX_BACKOFF} tx_state_t;
endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h1D35
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R7
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0);
endmodule

// File: rtl/hdx_defer_timer.sv
module hdx_defer_timer
  import hdx_pkg::*;
#(
  parameter int WINDOW_BITS = 60,
  parameter int TAIL_BITS   = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic full_duplex,
  input  logic carrier_sense,
  input  logic bit_tick,
  output logic gap_met
);
  localparam int MAXV = (WINDOW_BITS > TAIL_BITS) ? WINDOW_BITS : TAIL_BITS;
  localparam int CW   = $clog2(MAXV + 1);

  dfr_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy;

  assign busy = carrier_sense && !full_duplex;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!arm) begin
      st_d  = DF_WAIT;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        DF_WAIT: if (!busy) begin
          st_d  = DF_WIN;
          cnt_d = '0;
        end
        DF_WIN: begin
          if (busy) begin
            st_d = DF_WAIT;
          end else if (bit_tick) begin
            if (cnt_q == CW'(WINDOW_BITS - 1)) begin
              st_d  = DF_TAIL;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        DF_TAIL: if (bit_tick) begin
          if (cnt_q == CW'(TAIL_BITS - 1)) st_d = DF_MET;
          else                             cnt_d = cnt_q + 1'b1;
        end
        DF_MET: if (busy) st_d = DF_WAIT;
        default: st_d = DF_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DF_WAIT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign gap_met = (st_q == DF_TAIL && bit_tick && cnt_q == CW'(TAIL_BITS - 1)) ||
                   (st_q == DF_MET && !busy);

  // R3
  win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DF_WIN && busy) |=> (st_q == DF_WAIT));
  // R5
  met_from_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DF_MET && $past(st_q) != DF_MET) |-> ($past(st_q) == DF_TAIL));
endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff #(
  parameter int SLOT_BITS   = 512,
  parameter int BACKOFF_CAP = 10,
  parameter int N_W         = 5,
  parameter int LFSR_W      = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N_W-1:0] coll_n,
  input  logic           bit_tick,
  output logic           idle
);
  localparam int SW = $clog2(SLOT_BITS);

  logic [LFSR_W-1:0]      rnd;
  logic [BACKOFF_CAP-1:0] mask, slots_q, slots_d;
  logic [SW-1:0]          bit_q, bit_d;

  hdx_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .state(rnd));

  always_comb begin
    for (int i = 0; i < BACKOFF_CAP; i++) mask[i] = (int'(coll_n) > i);
  end

  always_comb begin
    slots_d = slots_q;
    bit_d   = bit_q;
    if (load) begin
      slots_d = rnd[BACKOFF_CAP-1:0] & mask;
      bit_d   = '0;
    end else if (slots_q != '0 && bit_tick) begin
      if (bit_q == SW'(SLOT_BITS - 1)) begin
        bit_d   = '0;
        slots_d = slots_q - 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q <= '0;
      bit_q   <= '0;
    end else begin
      slots_q <= slots_d;
      bit_q   <= bit_d;
    end
  end

  assign idle = (slots_q == '0);

  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (slots_q <= $past(mask)));
endmodule

// File: rtl/hdx_defer_retry.sv
module hdx_defer_retry
  import hdx_pkg::*;
#(
  parameter int WINDOW_BITS = 60,
  parameter int TAIL_BITS   = 36,
  parameter int SLOT_BITS   = 512,
  parameter int RETRY_LIMIT = 15,
  parameter int BACKOFF_CAP = 10,
  parameter int KEEP_BYTES  = 64,
  parameter int JAM_BITS    = 32,
  parameter int BC_W        = 16,
  parameter int LFSR_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            full_duplex,
  input  logic            bit_tick,
  input  logic            carrier_sense,
  input  logic            collision,
  input  logic            frame_pending,
  input  logic            frame_end,
  input  logic [BC_W-1:0] tx_byte_cnt,
  output logic            tx_grant,
  output logic            jam_req,
  output logic            rewind_req,
  output logic            late_col,
  output logic            retry_lim
);
  localparam int NW = $clog2(RETRY_LIMIT + 2);
  localparam int JW = $clog2(JAM_BITS + 1);

  tx_state_t     st_q, st_d;
  logic [NW-1:0] coll_q, coll_d;
  logic [JW-1:0] jcnt_q, jcnt_d;
  logic          late_q, late_d;
  logic          rw_q, rw_d, lc_q, lc_d, rl_q, rl_d;
  logic          gap_met, bo_idle, bo_load;

  hdx_defer_timer #(.WINDOW_BITS(WINDOW_BITS), .TAIL_BITS(TAIL_BITS)) u_defer (
    .clk(clk), .rst_n(rst_n), .arm(st_q == TX_DEFER), .full_duplex(full_duplex),
    .carrier_sense(carrier_sense), .bit_tick(bit_tick), .gap_met(gap_met));

  hdx_backoff #(.SLOT_BITS(SLOT_BITS), .BACKOFF_CAP(BACKOFF_CAP), .N_W(NW),
                .LFSR_W(LFSR_W)) u_backoff (
    .clk(clk), .rst_n(rst_n), .load(bo_load), .coll_n(coll_q),
    .bit_tick(bit_tick), .idle(bo_idle));

  always_comb begin
    st_d    = st_q;
    coll_d  = coll_q;
    jcnt_d  = jcnt_q;
    late_d  = late_q;
    rw_d    = 1'b0;
    lc_d    = 1'b0;
    rl_d    = 1'b0;
    bo_load = 1'b0;
    unique case (st_q)
      TX_DEFER: if (gap_met && frame_pending) st_d = TX_SEND;
      TX_SEND: begin
        if (collision && !full_duplex) begin
          st_d   = TX_JAM;
          jcnt_d = '0;
          late_d = (tx_byte_cnt >= BC_W'(KEEP_BYTES));
          coll_d = coll_q + 1'b1;
        end else if (frame_end) begin
          st_d   = TX_DEFER;
          coll_d = '0;
        end
      end
      TX_JAM: if (bit_tick) begin
        if (jcnt_q == JW'(JAM_BITS - 1)) begin
          if (late_q) begin
            lc_d   = 1'b1;
            coll_d = '0;
            st_d   = TX_DEFER;
          end else if (coll_q > NW'(RETRY_LIMIT)) begin
            rl_d   = 1'b1;
            coll_d = '0;
            st_d   = TX_DEFER;
          end else begin
            rw_d    = 1'b1;
            bo_load = 1'b1;
            st_d    = TX_BACKOFF;
          end
        end else begin
          jcnt_d = jcnt_q + 1'b1;
        end
      end
      TX_BACKOFF: if (bo_idle) st_d = TX_DEFER;
      default: st_d = TX_DEFER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_DEFER;
      coll_q <= '0;
      jcnt_q <= '0;
      late_q <= 1'b0;
      rw_q   <= 1'b0;
      lc_q   <= 1'b0;
      rl_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      coll_q <= coll_d;
      jcnt_q <= jcnt_d;
      late_q <= late_d;
      rw_q   <= rw_d;
      lc_q   <= lc_d;
      rl_q   <= rl_d;
    end
  end

  assign tx_grant   = (st_q == TX_SEND);
  assign jam_req    = (st_q == TX_JAM);
  assign rewind_req = rw_q;
  assign late_col   = lc_q;
  assign retry_lim  = rl_q;

  // R4
  grant_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_grant) |-> $past(gap_met));
  // R6
  jam_from_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_req) |-> ($past(collision) && !$past(full_duplex)));
  // R9
  late_no_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_col |-> (!rewind_req && !retry_lim && $past(late_q)));
  // R10
  limit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_lim |-> ($past(coll_q) == NW'(RETRY_LIMIT + 1)));
  // R11
  fd_no_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && $past(full_duplex)) |-> !$rose(jam_req));
endmodule

// File: tb/hdx_defer_retry_tb_top.sv
module hdx_defer_retry_tb_top;
  localparam int W = 6, T = 4, SL = 8, LIM = 3, CAP = 2, KEEP = 4, JAM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fd = 1'b0, tick = 1'b1, cs = 1'b1, col = 1'b0, pend = 1'b1, fend = 1'b0;
  logic [15:0] bcnt = '0;
  logic grant, jam, rw, lc, rl;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  hdx_defer_retry #(.WINDOW_BITS(W), .TAIL_BITS(T), .SLOT_BITS(SL), .RETRY_LIMIT(LIM),
    .BACKOFF_CAP(CAP), .KEEP_BYTES(KEEP), .JAM_BITS(JAM), .BC_W(16), .LFSR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .full_duplex(fd), .bit_tick(tick), .carrier_sense(cs),
    .collision(col), .frame_pending(pend), .frame_end(fend), .tx_byte_cnt(bcnt),
    .tx_grant(grant), .jam_req(jam), .rewind_req(rw), .late_col(lc), .retry_lim(rl));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic end_frame(input logic own_cs);
    @(negedge clk);
    fend = 1'b1;
    cs = own_cs;
    @(negedge clk);
    fend = 1'b0;
  endtask

  task automatic wait_grant();
    int n = 0;
    while (!grant && n < 2000) begin
      wn(1);
      n++;
    end
    chk(grant == 1'b1, "R7 grant returns", int'(grant), 1);
  endtask

  task automatic collide(input int b, output int jl, output int r, output int l, output int m);
    @(negedge clk);
    col = 1'b1;
    bcnt = 16'(b);
    @(negedge clk);
    col = 1'b0;
    chk(grant == 1'b0, "R6 grant dropped", int'(grant), 0);
    jl = 0;
    while (jam && jl < 100) begin
      jl++;
      wn(1);
    end
    r = int'(rw); l = int'(lc); m = int'(rl);
  endtask

  task automatic backoff_check(input int n);
    int d = 0, b, kmax;
    while (!grant && d < 2000) begin
      wn(1);
      d++;
    end
    b = d - 2 - W - T;
    kmax = (1 << ((n < CAP) ? n : CAP)) - 1;
    chk(b >= 0 && b % SL == 0, "R7 backoff whole slots", b, SL);
    chk(b / SL <= kmax, "R7 backoff slot range", b / SL, kmax);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int jl, r, l, m;
    wn(2);
    chk({grant, jam, rw, lc, rl} == 5'b0, "R1 reset outputs", int'({grant, jam, rw, lc, rl}), 0);
    rst_n = 1'b1;
    wn(1);
    chk({grant, jam, rw, lc, rl} == 5'b0, "R1 after release", int'({grant, jam, rw, lc, rl}), 0);
    wn(20);
    chk(grant == 1'b0, "R2 carrier holds off", int'(grant), 0);

    // R4 basic gap
    cs = 1'b0;
    wn(W + T);
    chk(grant == 1'b0, "R4 early", int'(grant), 0);
    wn(1);
    chk(grant == 1'b1, "R4 on time", int'(grant), 1);
    end_frame(1'b1);
    wn(3);

    // R3 carrier glitch at every window position
    for (int g = 1; g <= W; g++) begin
      cs = 1'b0;
      wn(g);
      cs = 1'b1;
      wn(1);
      cs = 1'b0;
      wn(W + T);
      chk(grant == 1'b0, "R3 restart early", int'(grant), 0);
      wn(1);
      chk(grant == 1'b1, "R3 restart on time", int'(grant), 1);
      end_frame(1'b1);
      wn(3);
    end

    // R5 carrier during tail ignored
    for (int g = W + 1; g <= W + T; g++) begin
      cs = 1'b0;
      wn(g);
      cs = 1'b1;
      chk(grant == 1'b0, "R5 tail early", int'(grant), 0);
      wn(W + T + 1 - g);
      chk(grant == 1'b1, "R5 tail not delayed", int'(grant), 1);
      end_frame(1'b1);
      wn(3);
    end

    // R11 full duplex
    fd = 1'b1;
    wait_grant();
    @(negedge clk);
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
    chk(grant == 1'b1 && jam == 1'b0, "R11 collision ignored", int'({grant, jam}), 2);
    wn(1);
    chk(jam == 1'b0, "R11 no jam", int'(jam), 0);
    end_frame(1'b1);
    wn(W + T);
    chk(grant == 1'b0, "R11 gap early", int'(grant), 0);
    wn(1);
    chk(grant == 1'b1, "R11 gap on time", int'(grant), 1);
    end_frame(1'b0);
    fd = 1'b0;

    // R8 R7 R10 retry sequence
    wait_grant();
    for (int n = 1; n <= LIM + 1; n++) begin
      collide(0, jl, r, l, m);
      chk(jl == JAM, "R6 jam length", jl, JAM);
      if (n <= LIM) begin
        chk(r == 1 && l == 0 && m == 0, "R8 early rewinds", r * 4 + l * 2 + m, 4);
        backoff_check(n);
      end else begin
        chk(m == 1 && r == 0 && l == 0, "R10 limit abort", r * 4 + l * 2 + m, 1);
        wait_grant();
      end
    end
    collide(0, jl, r, l, m);
    chk(r == 1 && m == 0, "R10 count restarts", r * 4 + l * 2 + m, 4);
    backoff_check(1);
    end_frame(1'b0);

    // R10 frame_end clears count: LIM collisions, end, then LIM more rewinds
    for (int rep = 0; rep < 2; rep++) begin
      wait_grant();
      for (int n = 1; n <= LIM; n++) begin
        collide(1, jl, r, l, m);
        chk(r == 1 && m == 0, "R10 cleared by frame_end", r * 4 + l * 2 + m, 4);
        backoff_check(n);
      end
      end_frame(1'b0);
    end

    // R9 late boundary sweep
    for (int b = 0; b <= KEEP + 1; b++) begin
      wait_grant();
      collide(b, jl, r, l, m);
      if (b < KEEP) begin
        chk(r == 1 && l == 0 && m == 0, "R8 below boundary", r * 4 + l * 2 + m, 4);
        backoff_check(1);
        end_frame(1'b0);
      end else begin
        chk(l == 1 && r == 0 && m == 0, "R9 late collision", r * 4 + l * 2 + m, 2);
        wn(1);
        chk(lc == 1'b0, "R9 single pulse", int'(lc), 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule